// File: doc/BRIEF.md
# Clause Register-Access Control Decoder

This block sits in the issue path of a shader core that has two execution pipes, a multiply-add pipe (FMA) and an add pipe (ADD). Each cycle it takes one register field from a clause of instructions. It turns that field into read requests for three register-file ports and into up to two register write commands. Each write command is tagged with the pipe whose result it stores.

Writes lag the reads. A field's write part belongs to the instruction before it. The field of the first instruction in a clause carries the writes of the clause's last instruction. The block therefore holds those writes and issues them in a separate flush cycle once the clause has ended. During that cycle the input is stalled through a ready output.

Port 0 carries only five address bits. To let both Port 0 and Port 1 reach all 64 registers, an out-of-order pair (Port 0 value greater than Port 1 value) signals that both true indices are 63 minus the encoded values.

Top module: `regfield_access_decoder`

## Requirements
- R1: The 35-bit field is packed, from LSB, as control [3:0], Port 1 [9:4], Port 0 [14:10], Port 2 [20:15], Port 3 [26:21] and uniform index [34:27]. A read through Port 2 (control 3, 4, 6, 12) raises rd2_en with rd2_addr equal to the Port 2 value, and a legal field drives uni_idx with its uniform index.
- R2: Control 1, 3 and 9 write the Port 3 register from FMA (wr0_en=1, wr0_add=0). Control 5, 6, 13 and 15 write it from ADD (wr0_add=1). Only control 15 adds a second FMA write to the Port 2 register (wr1_en, wr1_addr).
- R3: Control 11, and control 8 on a first instruction, request no Port 2 read and no write.
- R4: Control 8, 9, 12 or 13 on an instruction that is not first-of-clause raises dec_err and clears every read and write enable and every address for that instruction.
- R5: Control 0, 2, 7, 10 and 14 raise dec_err and clear all enables, whether or not the instruction is first.
- R6: Every legal instruction reads Port 1. Port 0 is read when its encoded value is nonzero. When the Port 0 value (zero-extended to six bits) is not greater than the Port 1 value, both addresses are output unchanged.
- R7: When the zero-extended Port 0 value is greater than the Port 1 value, rd0_addr is 63 minus the Port 0 value and rd1_addr is 63 minus the Port 1 value.
- R8: The writes in a first-of-clause field are not issued in their own output cycle. They are held instead, and an erroneous first field holds no writes.
- R9: After a last-of-clause input is accepted, in_ready is low for exactly one cycle. The held writes then appear on wr0/wr1 in the following output cycle, with no reads and no error, and the hold is emptied.
- R10: Outputs are registered, one cycle after the accepting edge. A synchronous reset clears all outputs and the held writes and sets in_ready high.
- R11: A field offered while in_ready is low is ignored: it produces no output, neither then nor later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Field present this cycle |
| in_first | input | 1 | Field is the first of its clause |
| in_last | input | 1 | Field is the last of its clause |
| in_field | input | 35 | Register field of the instruction word |
| in_ready | output | 1 | Low during the flush cycle after a clause end |
| rd0_en | output | 1 | Port 0 read request |
| rd0_addr | output | 6 | Port 0 true register index |
| rd1_en | output | 1 | Port 1 read request |
| rd1_addr | output | 6 | Port 1 true register index |
| rd2_en | output | 1 | Port 2 read request |
| rd2_addr | output | 6 | Port 2 register index |
| wr0_en | output | 1 | Write through Port 3 |
| wr0_addr | output | 6 | Port 3 write register |
| wr0_add | output | 1 | Port 3 write source: 1 ADD, 0 FMA |
| wr1_en | output | 1 | FMA write through Port 2 |
| wr1_addr | output | 6 | Port 2 write register |
| uni_idx | output | 8 | Uniform/constant index of the read instruction |
| dec_err | output | 1 | Illegal or misplaced control value |

## Verification
The properties assume that in_first, in_last and in_field are stable whenever in_valid is high, and that in_valid is low during reset. The stall property also assumes in_valid is low in the cycle right after reset, since it looks back one cycle to explain a low in_ready. The stimulus changes inputs only on falling edges. It holds in_valid low around reset. It deliberately keeps in_valid high with a different field during each flush cycle, so the properties see offered-but-refused traffic.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  // Control codes; the numeric values are the encoding carried in the field.
  typedef enum logic [3:0] {
    CC_WF      = 4'd1,
    CC_WF_R    = 4'd3,
    CC_R       = 4'd4,
    CC_WA      = 4'd5,
    CC_WA_R    = 4'd6,
    CC_F_NONE  = 4'd8,
    CC_F_WF    = 4'd9,
    CC_NONE    = 4'd11,
    CC_F_R     = 4'd12,
    CC_F_WA    = 4'd13,
    CC_WA_WF   = 4'd15
  } ctrl_e;

  typedef struct packed {
    logic legal;       // code is listed
    logic first_only;  // code allowed only on a clause's first field
    logic rd2;         // read through Port 2
    logic wa;          // write through Port 3
    logic wa_add;      // Port 3 write comes from ADD
    logic wb;          // FMA write through Port 2
  } acc_t;

endpackage

// File: rtl/ccd_ctrl_dec.sv
module ccd_ctrl_dec
  import ccd_pkg::*;
(
  input  logic [3:0] ctrl,
  output acc_t       acc
);

  always_comb begin
    acc       = '0;
    acc.legal = 1'b1;
    case (ctrl)
      CC_WF:     acc.wa = 1'b1;
      CC_WF_R:   begin acc.wa = 1'b1; acc.rd2 = 1'b1; end
      CC_R:      acc.rd2 = 1'b1;
      CC_WA:     begin acc.wa = 1'b1; acc.wa_add = 1'b1; end
      CC_WA_R:   begin acc.wa = 1'b1; acc.wa_add = 1'b1; acc.rd2 = 1'b1; end
      CC_WA_WF:  begin acc.wa = 1'b1; acc.wa_add = 1'b1; acc.wb = 1'b1; end
      CC_NONE:   ;
      CC_F_NONE: acc.first_only = 1'b1;
      CC_F_WF:   begin acc.first_only = 1'b1; acc.wa = 1'b1; end
      CC_F_R:    begin acc.first_only = 1'b1; acc.rd2 = 1'b1; end
      CC_F_WA:   begin acc.first_only = 1'b1; acc.wa = 1'b1; acc.wa_add = 1'b1; end
      default:   acc.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/ccd_pair_remap.sv
module ccd_pair_remap #(
  parameter int ADDR_W = 6,
  parameter int P0_W   = 5
) (
  input  logic [P0_W-1:0]   p0,
  input  logic [ADDR_W-1:0] p1,
  output logic              p0_use,
  output logic [ADDR_W-1:0] a0,
  output logic [ADDR_W-1:0] a1
);

  localparam logic [ADDR_W-1:0] TOP_REG = '1;

  logic [ADDR_W-1:0] p0x;
  logic              swap;

  assign p0x    = ADDR_W'(p0);
  assign p0_use = |p0;
  assign swap   = p0x > p1;
  assign a0     = swap ? (TOP_REG - p0x) : p0x;
  assign a1     = swap ? (TOP_REG - p1)  : p1;

endmodule

// File: rtl/regfield_access_decoder.sv
module regfield_access_decoder
  import ccd_pkg::*;
#(
  parameter int UNI_W  = 8,
  parameter int ADDR_W = 6,
  parameter int P0_W   = 5,
  parameter int CTRL_W = 4,
  localparam int P1_LO   = CTRL_W,
  localparam int P0_LO   = P1_LO + ADDR_W,
  localparam int P2_LO   = P0_LO + P0_W,
  localparam int P3_LO   = P2_LO + ADDR_W,
  localparam int UNI_LO  = P3_LO + ADDR_W,
  localparam int FIELD_W = UNI_LO + UNI_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_first,
  input  logic               in_last,
  input  logic [FIELD_W-1:0] in_field,
  output logic               in_ready,
  output logic               rd0_en,
  output logic [ADDR_W-1:0]  rd0_addr,
  output logic               rd1_en,
  output logic [ADDR_W-1:0]  rd1_addr,
  output logic               rd2_en,
  output logic [ADDR_W-1:0]  rd2_addr,
  output logic               wr0_en,
  output logic [ADDR_W-1:0]  wr0_addr,
  output logic               wr0_add,
  output logic               wr1_en,
  output logic [ADDR_W-1:0]  wr1_addr,
  output logic [UNI_W-1:0]   uni_idx,
  output logic               dec_err
);

  logic [CTRL_W-1:0] f_ctrl;
  logic [ADDR_W-1:0] f_p1, f_p2, f_p3;
  logic [P0_W-1:0]   f_p0;
  logic [UNI_W-1:0]  f_uni;

  assign f_ctrl = in_field[CTRL_W-1:0];
  assign f_p1   = in_field[P1_LO +: ADDR_W];
  assign f_p0   = in_field[P0_LO +: P0_W];
  assign f_p2   = in_field[P2_LO +: ADDR_W];
  assign f_p3   = in_field[P3_LO +: ADDR_W];
  assign f_uni  = in_field[UNI_LO +: UNI_W];

  acc_t              acc;
  logic              p0_use;
  logic [ADDR_W-1:0] a0, a1;

  ccd_ctrl_dec u_dec (
    .ctrl (f_ctrl),
    .acc  (acc)
  );

  ccd_pair_remap #(.ADDR_W(ADDR_W), .P0_W(P0_W)) u_remap (
    .p0     (f_p0),
    .p1     (f_p1),
    .p0_use (p0_use),
    .a0     (a0),
    .a1     (a1)
  );

  // flush cycle state and writes held from the clause's first field
  logic              flush_q;
  logic              hold_wa_en, hold_wa_add, hold_wb_en;
  logic [ADDR_W-1:0] hold_wa_a, hold_wb_a;

  logic take, bad;
  assign in_ready = !flush_q;
  assign take     = in_valid && in_ready;
  assign bad      = !acc.legal || (acc.first_only && !in_first);

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q     <= 1'b0;
      hold_wa_en  <= 1'b0;
      hold_wa_add <= 1'b0;
      hold_wa_a   <= '0;
      hold_wb_en  <= 1'b0;
      hold_wb_a   <= '0;
      rd0_en      <= 1'b0;
      rd0_addr    <= '0;
      rd1_en      <= 1'b0;
      rd1_addr    <= '0;
      rd2_en      <= 1'b0;
      rd2_addr    <= '0;
      wr0_en      <= 1'b0;
      wr0_addr    <= '0;
      wr0_add     <= 1'b0;
      wr1_en      <= 1'b0;
      wr1_addr    <= '0;
      uni_idx     <= '0;
      dec_err     <= 1'b0;
    end else begin
      rd0_en   <= 1'b0;
      rd0_addr <= '0;
      rd1_en   <= 1'b0;
      rd1_addr <= '0;
      rd2_en   <= 1'b0;
      rd2_addr <= '0;
      wr0_en   <= 1'b0;
      wr0_addr <= '0;
      wr0_add  <= 1'b0;
      wr1_en   <= 1'b0;
      wr1_addr <= '0;
      uni_idx  <= '0;
      dec_err  <= 1'b0;
      flush_q  <= take && in_last;
      if (take) begin
        if (bad) begin
          dec_err <= 1'b1;
          if (in_first) begin
            hold_wa_en  <= 1'b0;
            hold_wa_add <= 1'b0;
            hold_wa_a   <= '0;
            hold_wb_en  <= 1'b0;
            hold_wb_a   <= '0;
          end
        end else begin
          uni_idx  <= f_uni;
          rd0_en   <= p0_use;
          rd0_addr <= p0_use ? a0 : '0;
          rd1_en   <= 1'b1;
          rd1_addr <= a1;
          rd2_en   <= acc.rd2;
          rd2_addr <= acc.rd2 ? f_p2 : '0;
          if (in_first) begin
            hold_wa_en  <= acc.wa;
            hold_wa_add <= acc.wa_add;
            hold_wa_a   <= acc.wa ? f_p3 : '0;
            hold_wb_en  <= acc.wb;
            hold_wb_a   <= acc.wb ? f_p2 : '0;
          end else begin
            wr0_en   <= acc.wa;
            wr0_add  <= acc.wa_add;
            wr0_addr <= acc.wa ? f_p3 : '0;
            wr1_en   <= acc.wb;
            wr1_addr <= acc.wb ? f_p2 : '0;
          end
        end
      end else if (flush_q) begin
        wr0_en      <= hold_wa_en;
        wr0_add     <= hold_wa_add;
        wr0_addr    <= hold_wa_a;
        wr1_en      <= hold_wb_en;
        wr1_addr    <= hold_wb_a;
        hold_wa_en  <= 1'b0;
        hold_wa_add <= 1'b0;
        hold_wa_a   <= '0;
        hold_wb_en  <= 1'b0;
        hold_wb_a   <= '0;
      end
    end
  end

endmodule

// File: rtl/regfield_access_decoder_chk.sv
module regfield_access_decoder_chk #(
  parameter int ADDR_W = 6,
  parameter int P0_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_first,
  input logic              in_last,
  input logic              in_ready,
  input logic [3:0]        ctrl,
  input logic [P0_W-1:0]   p0,
  input logic [ADDR_W-1:0] p1,
  input logic              rd0_en,
  input logic              rd1_en,
  input logic [ADDR_W-1:0] rd1_addr,
  input logic              rd2_en,
  input logic              wr0_en,
  input logic              wr0_add,
  input logic              wr1_en,
  input logic              dec_err
);

  localparam logic [ADDR_W-1:0] TOP_REG = '1;

  logic acc_in;
  assign acc_in = in_valid && in_ready;

  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> !(rd0_en || rd1_en || rd2_en || wr0_en || wr1_en));

  // R4
  first_only_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_in && !in_first && (ctrl == 4'd8 || ctrl == 4'd9 || ctrl == 4'd12 || ctrl == 4'd13))
      |=> dec_err);

  // R2
  wr1_pair_chk: assert property (@(posedge clk) disable iff (rst)
    wr1_en |-> (wr0_en && wr0_add));

  // R7
  remap_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_in && (ADDR_W'(p0) > p1)) |=> (dec_err || rd1_addr == TOP_REG - $past(p1)));

  // R8
  first_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_in && in_first) |=> (!wr0_en && !wr1_en));

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_in && in_last) |=> !in_ready);

  // R9
  ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> $past(acc_in && in_last));

  // R9
  flush_noread_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> !(rd0_en || rd1_en || rd2_en || dec_err));

endmodule

bind regfield_access_decoder regfield_access_decoder_chk #(
  .ADDR_W (ADDR_W),
  .P0_W   (P0_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_first (in_first),
  .in_last  (in_last),
  .in_ready (in_ready),
  .ctrl     (in_field[3:0]),
  .p0       (in_field[P0_LO +: P0_W]),
  .p1       (in_field[P1_LO +: ADDR_W]),
  .rd0_en   (rd0_en),
  .rd1_en   (rd1_en),
  .rd1_addr (rd1_addr),
  .rd2_en   (rd2_en),
  .wr0_en   (wr0_en),
  .wr0_add  (wr0_add),
  .wr1_en   (wr1_en),
  .dec_err  (dec_err)
);

// File: tb/regfield_access_decoder_test.sv
`timescale 1ns/1ps
module regfield_access_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [34:0] in_field = '0;
  logic        in_ready;
  logic        rd0_en, rd1_en, rd2_en, wr0_en, wr0_add, wr1_en, dec_err;
  logic [5:0]  rd0_addr, rd1_addr, rd2_addr, wr0_addr, wr1_addr;
  logic [7:0]  uni_idx;

  always #10 clk = ~clk;

  regfield_access_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
    .in_field(in_field), .in_ready(in_ready),
    .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd1_en(rd1_en), .rd1_addr(rd1_addr),
    .rd2_en(rd2_en), .rd2_addr(rd2_addr), .wr0_en(wr0_en), .wr0_addr(wr0_addr),
    .wr0_add(wr0_add), .wr1_en(wr1_en), .wr1_addr(wr1_addr), .uni_idx(uni_idx),
    .dec_err(dec_err)
  );

  // {err, uni, rd0_en, rd0, rd1_en, rd1, rd2_en, rd2, wr0_en, wr0, wr0_add, wr1_en, wr1}
  logic [44:0] got;
  assign got = {dec_err, uni_idx, rd0_en, rd0_addr, rd1_en, rd1_addr, rd2_en, rd2_addr,
                wr0_en, wr0_addr, wr0_add, wr1_en, wr1_addr};

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [14:0] hold = '0;

  // {first, last, uni, p3, p2, p0, p1, ctrl}
  localparam int NV = 20;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'hA5, 6'd12, 6'd7,  5'd3,  6'd40, 4'd9},
    {1'b0, 1'b0, 8'h11, 6'd20, 6'd21, 5'd0,  6'd5,  4'd3},
    {1'b0, 1'b1, 8'h22, 6'd30, 6'd31, 5'd20, 6'd10, 4'd15},
    {1'b1, 1'b1, 8'h33, 6'd50, 6'd4,  5'd31, 6'd0,  4'd13},
    {1'b1, 1'b0, 8'h44, 6'd17, 6'd9,  5'd5,  6'd5,  4'd12},
    {1'b0, 1'b0, 8'h55, 6'd8,  6'd63, 5'd0,  6'd63, 4'd4},
    {1'b0, 1'b0, 8'h56, 6'd8,  6'd33, 5'd5,  6'd9,  4'd4},
    {1'b0, 1'b0, 8'h66, 6'd1,  6'd6,  5'd1,  6'd2,  4'd5},
    {1'b0, 1'b0, 8'h77, 6'd2,  6'd3,  5'd31, 6'd63, 4'd6},
    {1'b0, 1'b0, 8'h88, 6'd9,  6'd9,  5'd2,  6'd1,  4'd11},
    {1'b0, 1'b0, 8'h99, 6'd63, 6'd0,  5'd0,  6'd14, 4'd1},
    {1'b0, 1'b0, 8'hAA, 6'd5,  6'd5,  5'd4,  6'd8,  4'd8},
    {1'b0, 1'b0, 8'hBB, 6'd5,  6'd5,  5'd4,  6'd8,  4'd7},
    {1'b0, 1'b1, 8'hCC, 6'd5,  6'd5,  5'd4,  6'd8,  4'd0},
    {1'b1, 1'b0, 8'hDD, 6'd40, 6'd41, 5'd1,  6'd1,  4'd2},
    {1'b0, 1'b1, 8'hEE, 6'd42, 6'd43, 5'd2,  6'd3,  4'd11},
    {1'b1, 1'b0, 8'h01, 6'd44, 6'd45, 5'd9,  6'd9,  4'd8},
    {1'b0, 1'b0, 8'h02, 6'd46, 6'd47, 5'd9,  6'd9,  4'd10},
    {1'b0, 1'b0, 8'h03, 6'd48, 6'd49, 5'd9,  6'd9,  4'd14},
    {1'b0, 1'b1, 8'h04, 6'd59, 6'd60, 5'd30, 6'd29, 4'd13}
  };

  // Independent model of the requirements: returns reads/uni/err, writes via wr.
  function automatic logic [44:0] model(input logic [34:0] f, input logic first,
                                        output logic [14:0] wr, output string tag);
    logic [3:0] c;
    logic [5:0] p1, p2, p3, p0x, a0, a1;
    logic       fo, r2, wa, wadd, wb, ill, sw, err;
    c = f[3:0]; p1 = f[9:4]; p0x = {1'b0, f[14:10]}; p2 = f[20:15]; p3 = f[26:21];
    {fo, r2, wa, wadd, wb, ill} = '0;
    case (c)
      4'd1:  wa = 1;
      4'd3:  begin wa = 1; r2 = 1; end
      4'd4:  r2 = 1;
      4'd5:  begin wa = 1; wadd = 1; end
      4'd6:  begin wa = 1; wadd = 1; r2 = 1; end
      4'd11: ;
      4'd15: begin wa = 1; wadd = 1; wb = 1; end
      4'd8:  fo = 1;
      4'd9:  begin fo = 1; wa = 1; end
      4'd12: begin fo = 1; r2 = 1; end
      4'd13: begin fo = 1; wa = 1; wadd = 1; end
      default: ill = 1;
    endcase
    err = ill || (fo && !first);
    sw  = p0x > p1;
    a0  = sw ? 6'd63 - p0x : p0x;
    a1  = sw ? 6'd63 - p1  : p1;
    if (err) begin
      wr = '0;
      tag = (ill) ? "R5" : "R4";
      return {1'b1, 44'd0};
    end
    wr = {wa, wa ? p3 : 6'd0, wadd, wb, wb ? p2 : 6'd0};
    if (first) tag = "R8";
    else if (sw) tag = "R7";
    else if (c == 4'd11) tag = "R3";
    else if (wa) tag = "R2";
    else if (p0x != 0) tag = "R6";
    else tag = "R1";
    if (first && c == 4'd8) tag = "R3";
    return {1'b0, f[34:27], p0x != 0, (p0x != 0) ? a0 : 6'd0, 1'b1, a1,
            r2, r2 ? p2 : 6'd0, 15'd0};
  endfunction

  task automatic check(input string tag, input logic [44:0] act, input logic [44:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [36:0] v);
    logic [44:0] exp;
    logic [14:0] wr;
    string tag;
    in_valid = 1'b1; in_first = v[36]; in_last = v[35]; in_field = v[34:0];
    exp = model(v[34:0], v[36], wr, tag);
    if (v[36]) hold = wr;
    else exp[14:0] = wr;
    @(negedge clk);
    check(tag, got, exp);
    if (v[35]) begin
      check("R9", {44'd0, in_ready}, 45'd0);
      // R11: refused field offered during the flush cycle
      in_first = 1'b1; in_last = 1'b1; in_field = {8'hFF, 6'd33, 6'd34, 5'd7, 6'd2, 4'd5};
      @(negedge clk);
      check("R9", got, {30'd0, hold});
      hold = '0;
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
      @(negedge clk);
      check("R11", {got, in_ready}, {45'd0, 1'b1});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", {got, in_ready}, {45'd0, 1'b1});
    rst = 1'b0;
    @(negedge clk);
    check("R10", {got, in_ready}, {45'd0, 1'b1});

    for (int i = 0; i < NV; i++) step(VEC[i]);

    // R10: reset in mid-clause discards held writes
    step({1'b1, 1'b0, 8'h10, 6'd22, 6'd23, 5'd1, 6'd1, 4'd9});
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R10", {got, in_ready}, {45'd0, 1'b1});
    rst = 1'b0;
    hold = '0;
    step({1'b0, 1'b1, 8'h20, 6'd24, 6'd25, 5'd0, 6'd3, 4'd11});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule